// File: doc/BRIEF.md
# Serial Audio Slave Receiver with Word-Length Adaptation

This block receives two-channel serial audio from an external master. The master supplies the bit clock, the word select and the data, so all three are inputs here. They are brought into the system clock domain through a two-flop synchronizer. Data and word select are both sampled on each detected rising edge of the bit clock.

Word select low marks the left channel and high marks the right channel. The most significant bit of a word arrives one bit clock after word select changes. The bit sampled on the edge where word select changes is therefore the last bit of the word that is ending.

Each completed word is fitted into `WORD_W` bits and left-aligned there. Bits beyond the configured width are dropped. Missing low-order bits are filled with zeros. After a right word completes, the block presents the left/right pair of that frame with a one-cycle valid strobe.

The control state machine has four states:
- IDLE: the block is disabled.
- SEEK: the block waits for a right-to-left word boundary.
- LEFT: a left word is being captured.
- RIGHT: a right word is being captured.

Its transitions are:
- enable (IDLE to SEEK)
- lock (SEEK to LEFT, on a right-to-left boundary)
- left_done (LEFT to RIGHT, on a word boundary)
- pair_done (RIGHT to LEFT, on a word boundary, issuing the valid strobe)
- disable (any state to IDLE when the enable input is low)

Top module: `i2s_slave_rx`

## Requirements
- R1: While reset is asserted and after its release, `left_o` and `right_o` read zero and `valid_o` is low until the first complete frame.
- R2: Data and word select are sampled on rising bit-clock edges. A sampled word select of 0 assigns bits to the left word and 1 to the right word. `valid_o` presents the left and right words of the same frame.
- R3: The first bit sampled after a word-select change is the MSB of the new word. The bit sampled on the edge where word select changes is the final bit of the previous word.
- R4: When a word carries more bits than `WORD_W`, only its first `WORD_W` bits are kept. Later bits are ignored, and the internal bit count never exceeds `WORD_W`.
- R5: When a word carries fewer than `WORD_W` bits, its bits occupy the top positions and every unfilled low-order bit is zero.
- R6: When a word carries exactly `WORD_W` bits, it is output unchanged.
- R7: Output words are two's complement. Output bit `WORD_W-1` is the first transmitted bit of the word (its sign), for any word length of one or more.
- R8: After reset or after the enable input rises, no pair is output until a complete left word has been captured. That left word must begin at a high-to-low word-select change seen while enabled.
- R9: While `en_i` is low, `valid_o` stays low, `left_o`/`right_o` hold their values, and the control returns to IDLE on the next cycle.
- R10: `valid_o` is a single system-clock pulse, and it is raised only when leaving the RIGHT state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Receive enable (system clock domain) |
| sck_i | input | 1 | Bit clock from the external master |
| ws_i | input | 1 | Word select from the external master (0 left, 1 right) |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | WORD_W | Left sample of the last completed frame |
| right_o | output | WORD_W | Right sample of the last completed frame |
| valid_o | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench builds the block with `WORD_W = 16` and a two-stage synchronizer. It drives transmitted word lengths from 1 to 28 bits, chosen independently for the two channels. That range brings truncation, zero padding and the exact-fit case within reach, as well as single-bit words where the sign bit alone survives. The bench also starts the stream in mid-frame and toggles the enable between words. This exercises the discard of partial frames and the holding of outputs while disabled.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SEEK  = 2'd1,
        RX_LEFT  = 2'd2,
        RX_RIGHT = 2'd3
    } rx_state_e;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2s_rx_place.sv
module i2s_rx_place #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              clr_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    logic [WORD_W-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;

    // Current bit dropped into the slot selected by the count; no slot once full.
    always_comb begin
        word_o = acc_q;
        for (int i = 0; i < WORD_W; i++) begin
            if (cnt_q == CNT_W'(WORD_W - 1 - i)) word_o[i] = bit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (step_i) begin
            if (clr_i) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= word_o;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx
    import i2s_rx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              sck_i,
    input  logic              ws_i,
    input  logic              sd_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [2:0]        sync_q;
    logic              sck_s, ws_s, sd_s;
    logic              sck_prev_q, ws_prev_q;
    logic              rise, boundary, capturing;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] left_hold_q;
    rx_state_e         state_q, state_n;

    i2s_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({sck_i, ws_i, sd_i}),
        .q_o   (sync_q)
    );
    assign {sck_s, ws_s, sd_s} = sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sck_prev_q <= 1'b0;
            ws_prev_q  <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            if (rise) ws_prev_q <= ws_s;
        end
    end

    assign rise      = sck_s & ~sck_prev_q;
    assign boundary  = rise & (ws_s != ws_prev_q);
    assign capturing = (state_q == RX_LEFT) || (state_q == RX_RIGHT);

    i2s_rx_place #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_place (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .step_i(rise),
        .clr_i (boundary | ~capturing),
        .bit_i (sd_s),
        .word_o(word),
        .cnt_o (bit_cnt)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RX_IDLE;
        else         state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RX_IDLE:  if (en_i) state_n = RX_SEEK;
            RX_SEEK:  begin
                if (!en_i) state_n = RX_IDLE;
                else if (boundary && ws_prev_q && !ws_s) state_n = RX_LEFT;
            end
            RX_LEFT:  begin
                if (!en_i) state_n = RX_IDLE;
                else if (boundary) state_n = RX_RIGHT;
            end
            RX_RIGHT: begin
                if (!en_i) state_n = RX_IDLE;
                else if (boundary) state_n = RX_LEFT;
            end
            default:  state_n = RX_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            left_hold_q <= '0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (en_i && boundary) begin
                if (state_q == RX_LEFT) left_hold_q <= word;
                if (state_q == RX_RIGHT) begin
                    left_o  <= left_hold_q;
                    right_o <= word;
                    valid_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_slave_rx_chk.sv
module i2s_slave_rx_chk
    import i2s_rx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              valid_o,
    input logic [WORD_W-1:0] left_o,
    input logic [WORD_W-1:0] right_o,
    input rx_state_e         state_q,
    input logic [CNT_W-1:0]  bit_cnt
);
    a_r10_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    a_r10_valid_from_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(state_q) == RX_RIGHT);

    a_r9_no_valid_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !valid_o);

    a_r9_idle_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> state_q == RX_IDLE);

    a_r9_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_cnt <= CNT_W'(WORD_W));
endmodule

bind i2s_slave_rx i2s_slave_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .valid_o(valid_o),
    .left_o (left_o),
    .right_o(right_o),
    .state_q(state_q),
    .bit_cnt(bit_cnt)
);

// File: tb/i2s_slave_rx_tb_top.sv
`timescale 1ns/1ps
module i2s_slave_rx_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         sck = 1'b0;
    logic         ws = 1'b0;
    logic         sd = 1'b0;
    logic [W-1:0] left_o, right_o;
    logic         valid_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic carry = 1'b0;
    logic prev_valid = 1'b0;
    logic [W-1:0] exp_l[$];
    logic [W-1:0] exp_r[$];

    always #2.5 clk = ~clk;

    i2s_slave_rx #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .en_i   (en),
        .sck_i  (sck),
        .ws_i   (ws),
        .sd_i   (sd),
        .left_o (left_o),
        .right_o(right_o),
        .valid_o(valid_o)
    );

    // Expected output word: first min(n,W) transmitted bits, MSB first, zeros below.
    function automatic logic [W-1:0] adapt(input logic [31:0] v, input int n);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++) begin
            if (i < n) r[W-1-i] = v[n-1-i];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_period(input logic w, input logic d);
        @(posedge clk); #1;
        sck = 1'b0; ws = w; sd = d;
        repeat (4) @(posedge clk);
        #1 sck = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    // Period 0 of a slot carries the LSB of the previous word (R3).
    task automatic send_word(input logic c, input logic [31:0] v, input int n);
        for (int j = 0; j < n; j++) bit_period(c, (j == 0) ? carry : v[n-j]);
        carry = v[0];
    endtask

    task automatic send_frame(input logic [31:0] l, input int nl,
                              input logic [31:0] r, input int nr, input bit expect_out);
        if (expect_out) begin
            exp_l.push_back(adapt(l, nl));
            exp_r.push_back(adapt(r, nr));
        end
        send_word(1'b0, l, nl);
        send_word(1'b1, r, nr);
    endtask

    // Output monitor (R2, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o && prev_valid)
                check(1'b0, "R10 valid wider than one cycle", {W{1'b1}}, '0);
            if (valid_o) begin
                if (exp_l.size() == 0) begin
                    check(1'b0, "R8/R9 unexpected valid", left_o, '0);
                end else begin
                    logic [W-1:0] el, er;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    check(left_o == el, "R2/R3 left word", left_o, el);
                    check(right_o == er, "R2/R3 right word", right_o, er);
                end
            end
            prev_valid <= valid_o;
        end
    end

    initial begin
        #(150000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_l.size());
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        #1;
        check(left_o == '0 && right_o == '0 && valid_o == 1'b0, "R1 reset outputs",
              left_o, '0);
        #20 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(left_o == '0 && right_o == '0 && valid_o == 1'b0, "R1 after reset",
              right_o, '0);

        // R8: stream starts in mid frame; first pair discarded
        en = 1'b1;
        send_frame(32'h1111, 16, 32'h2222, 16, 1'b0);
        send_frame(32'hA5C3, 16, 32'h3C5A, 16, 1'b1);

        // Directed corner cases
        send_frame(32'h8001, 16, 32'h7FFE, 16, 1'b1);          // R6 exact fit
        send_frame(32'hABCDEF, 24, 32'h123456, 24, 1'b1);      // R4 truncation
        send_frame(32'h15, 5, 32'h0A, 5, 1'b1);                // R5 zero padding
        send_frame(32'h1, 1, 32'h0, 1, 1'b1);                  // R7 sign bit only
        send_frame(32'hF0F, 12, 32'hFFFF80, 24, 1'b1);         // R7 negative values
        send_frame(32'h0FFFFFF, 28, 32'h3, 2, 1'b1);           // R4/R5 mixed

        // Random frames
        for (int k = 0; k < 60; k++) begin
            int nl, nr;
            nl = 1 + int'($urandom_range(27));
            nr = 1 + int'($urandom_range(27));
            send_frame($urandom, nl, $urandom, nr, 1'b1);
        end

        // R9: disable between words, outputs hold, then relock
        send_frame(32'hBEEF, 16, 32'hCAFE, 16, 1'b1);
        send_word(1'b0, 32'h1357, 16);
        en = 1'b0;
        send_word(1'b1, 32'h2468, 16);
        send_word(1'b0, 32'h9999, 16);
        #1;
        check(left_o == 16'hBEEF, "R9 left held while disabled", left_o, 16'hBEEF);
        check(right_o == 16'hCAFE, "R9 right held while disabled", right_o, 16'hCAFE);
        check(valid_o == 1'b0, "R9 no valid while disabled", {15'd0, valid_o}, '0);
        en = 1'b1;
        send_word(1'b1, 32'h4444, 16);                        // R8 discarded after enable
        send_frame(32'h6A6A, 20, 32'h0F, 4, 1'b1);
        send_word(1'b0, 32'h0, 8);
        repeat (20) @(posedge clk);
        #1;
        check(exp_l.size() == 0, "R8 all expected pairs seen", W'(exp_l.size()), '0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule